// File: doc/BRIEF.md
# Slave Response Receiver with Busy Polling

This block takes over the serial data line once a command frame has gone out to a slave. It keeps the line driven idle for a fixed number of bus clocks so the slave can turn around. It then releases the line and samples one bit per bus clock until a start bit appears. If no start bit arrives within a bounded number of samples, the block gives up. Once the start bit is seen, it collects a slave id, a two-bit response tag, read data when the tag and the request call for it, and a four-bit check code. The check code is verified as a running residue that also covers the start bit.

A busy tag starts a retry loop. The block clocks filler bits, asks the frame transmitter for a data-poll frame through a request/acknowledge handshake, and then waits for the next response. After a bounded number of busy answers it asks for a terminate frame instead and reports a stuck slave. Every finished operation, whether it succeeded or not, ends with a run of priming filler clocks and a one-cycle done pulse that carries a three-bit result code. The read data is presented byte by byte and stays put until the next request.

Top module: `slave_resp_rx`

## Requirements
- R1: After reset, lineOe, busTick, txReq and done are low, errCode is 0 and rdData is 0.
- R2: On startReq in idle, the block drives the line high (lineOe=1, lineOut=1) for ECHO_CLKS bus clocks. It then releases the line (lineOe=0) and samples lineIn once per busTick. A low line level is logical 1.
- R3: While it waits for the start bit (logical 1), it takes at most START_WAIT samples. A start bit on the last of those samples is accepted. If none arrives, the result code is 4.
- R4: After the start bit it reads 2 id bits, then 2 tag bits, most significant bit first. A correct response with tag 0 (acknowledge) gives code 0. Tag 2 gives code 2. Tag 3 gives code 3.
- R5: Data bits (8 per byte, sizeBytes bytes) are sampled only for a read request with tag 0. Every response ends with 4 check bits.
- R6: The check is a CRC with polynomial x^4+x^2+x+1, processed MSB first from a zero seed, over the start bit, id, tag, data and received check bits. A residue other than zero gives code 5, and this takes precedence over the tag.
- R7: A busy tag (1) with a good check is followed by FILL_CLKS driven-high filler clocks. The block then raises txReq with txKind=0 (data poll) and, after txDone, runs the echo delay and receives again.
- R8: The busy answer numbered MAX_BUSY+1 within one operation leads, after the filler clocks, to txKind=1 (terminate), an echo delay and one more receive. The code is then 1, whatever that last response holds.
- R9: Every operation ends with PRIME_CLKS driven-high clocks, followed by done high for exactly one cycle with errCode valid. errCode holds until the next done.
- R10: Received byte k (k=0 first) appears at rdData[8k+7:8k], most significant bit received first. Bytes not received read 0. rdData is cleared on each accepted startReq and is otherwise held.
- R11: startReq while an operation is running has no effect.
- R12: txReq stays high until txDone is seen, and it drops in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each busTick is one bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin receiving after a command frame |
| isRead | input | 1 | The request expects read data |
| sizeBytes | input | $clog2(MAX_BYTES+1) | Read size in bytes |
| lineIn | input | 1 | Data line level (low = logical 1) |
| lineOe | output | 1 | Block drives the data line |
| lineOut | output | 1 | Driven line level |
| busTick | output | 1 | A bus clock is issued this cycle |
| txReq | output | 1 | Request a frame from the transmitter |
| txKind | output | 1 | 0 = data poll, 1 = terminate |
| txDone | input | 1 | Transmitter finished the requested frame |
| done | output | 1 | One-cycle end-of-operation pulse |
| errCode | output | 3 | 0 ok, 1 stuck busy, 2 misc, 3 slave CRC, 4 timeout, 5 response CRC |
| rdData | output | 8*MAX_BYTES | Received read bytes |

## Verification
The bench keeps ECHO_CLKS=16, FILL_CLKS=100, PRIME_CLKS=100 and MAX_BYTES=4 at their defaults, so the filler and echo runs it measures are the real lengths. START_WAIT is cut to 50 and MAX_BUSY to 3. This puts both timeout edges (start bit on the last sample, and no start bit) and the full stuck-busy path with its terminate fallback within a few thousand cycles.

// File: rtl/slave_resp_rx_pkg.sv
package slave_resp_rx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ECHO, ST_WAIT, ST_HEAD, ST_DATA,
    ST_CRC, ST_CHECK, ST_FILL, ST_TXWAIT, ST_PRIME
  } rxState_e;

  typedef enum logic {TX_POLL = 1'b0, TX_TERM = 1'b1} txKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic clrFrame;
    logic takeHdr;
    logic takeData;
    logic takeCrc;
  } rxStrobe_t;

  localparam logic [1:0] TAG_ACK  = 2'd0;
  localparam logic [1:0] TAG_BUSY = 2'd1;
  localparam logic [1:0] TAG_MISC = 2'd2;

  localparam logic [2:0] C_OK      = 3'd0;
  localparam logic [2:0] C_STUCK   = 3'd1;
  localparam logic [2:0] C_MISC    = 3'd2;
  localparam logic [2:0] C_SLVCRC  = 3'd3;
  localparam logic [2:0] C_TIMEOUT = 3'd4;
  localparam logic [2:0] C_RESPCRC = 3'd5;

  function automatic logic [3:0] crcStep(input logic [3:0] c, input logic b,
                                         input logic [3:0] poly);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? poly : 4'h0);
  endfunction

endpackage

// File: rtl/slave_resp_rx_dp.sv
module slave_resp_rx_dp
  import slave_resp_rx_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter logic [3:0] CRC_POLY = 4'h7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxStrobe_t              strobe,
  input  logic                   lineIn,
  output logic                   bitVal,
  output logic [1:0]             tagLive,
  output logic [1:0]             tagReg,
  output logic                   crcZero,
  output logic [MAX_BYTES*8-1:0] rdData
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [3:0]       crcReg;
  logic [3:0]       hdr;
  logic [6:0]       partial;
  logic [2:0]       bitPos;
  logic [IDX_W-1:0] byteIdx;
  logic             byteDone;
  logic [7:0]       fullByte;

  assign bitVal   = ~lineIn;            // line is active low
  assign tagLive  = {hdr[0], bitVal};   // tag as it completes this cycle
  assign tagReg   = hdr[1:0];
  assign crcZero  = (crcReg == 4'h0);
  assign byteDone = strobe.takeData && (bitPos == 3'd7);
  assign fullByte = {partial, bitVal};

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      crcReg  <= 4'h0;
      hdr     <= 4'h0;
      partial <= 7'h0;
      bitPos  <= 3'd0;
      byteIdx <= '0;
    end else if (strobe.clrFrame) begin
      crcReg  <= crcStep(4'h0, 1'b1, CRC_POLY);  // start bit is covered
      hdr     <= 4'h0;
      partial <= 7'h0;
      bitPos  <= 3'd0;
      byteIdx <= '0;
    end else begin
      if (strobe.takeHdr || strobe.takeData || strobe.takeCrc)
        crcReg <= crcStep(crcReg, bitVal, CRC_POLY);
      if (strobe.takeHdr)
        hdr <= {hdr[2:0], bitVal};
      if (strobe.takeData) begin
        partial <= {partial[5:0], bitVal};
        bitPos  <= bitPos + 3'd1;
        if (byteDone) byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrAll)
        rdData[g*8 +: 8] <= 8'h00;
      else if (byteDone && byteIdx == IDX_W'(g))
        rdData[g*8 +: 8] <= fullByte;
    end
  end

  p_crc_seed_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFrame |=> (crcReg == CRC_POLY));

endmodule

// File: rtl/slave_resp_rx_ctrl.sv
module slave_resp_rx_ctrl
  import slave_resp_rx_pkg::*;
#(
  parameter int ECHO_CLKS  = 16,
  parameter int START_WAIT = 1000,
  parameter int FILL_CLKS  = 100,
  parameter int PRIME_CLKS = 100,
  parameter int MAX_BUSY   = 100,
  parameter int MAX_BYTES  = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startReq,
  input  logic                           isRead,
  input  logic [$clog2(MAX_BYTES+1)-1:0] sizeBytes,
  input  logic                           bitVal,
  input  logic [1:0]                     tagLive,
  input  logic [1:0]                     tagReg,
  input  logic                           crcZero,
  input  logic                           txDone,
  output rxStrobe_t                      strobe,
  output logic                           busTick,
  output logic                           lineOe,
  output logic                           txReq,
  output txKind_e                        txKind,
  output logic                           done,
  output logic [2:0]                     errCode
);
  localparam int SZ_W     = $clog2(MAX_BYTES+1);
  localparam int DATA_MAX = MAX_BYTES * 8;
  localparam int M1       = (ECHO_CLKS > START_WAIT) ? ECHO_CLKS : START_WAIT;
  localparam int M2       = (FILL_CLKS > PRIME_CLKS) ? FILL_CLKS : PRIME_CLKS;
  localparam int M3       = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX  = (M3 > DATA_MAX) ? M3 : DATA_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BUSY_W   = $clog2(MAX_BUSY + 1);

  localparam logic [CNT_W-1:0]  ECHO_LAST  = CNT_W'(ECHO_CLKS - 1);
  localparam logic [CNT_W-1:0]  WAIT_LAST  = CNT_W'(START_WAIT - 1);
  localparam logic [CNT_W-1:0]  FILL_LAST  = CNT_W'(FILL_CLKS - 1);
  localparam logic [CNT_W-1:0]  PRIME_LAST = CNT_W'(PRIME_CLKS - 1);
  localparam logic [CNT_W-1:0]  NIB_LAST   = CNT_W'(3);
  localparam logic [BUSY_W-1:0] BUSY_LIM   = BUSY_W'(MAX_BUSY);
  localparam logic [SZ_W-1:0]   SZ_LIM     = SZ_W'(MAX_BYTES);

  rxState_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nBits;
  logic [BUSY_W-1:0] busyCnt;
  logic              termMode;
  logic [2:0]        pend;
  logic [SZ_W-1:0]   szEff;

  assign szEff = (sizeBytes > SZ_LIM) ? SZ_LIM : sizeBytes;

  always_comb begin
    strobe          = '0;
    strobe.clrAll   = (state == ST_IDLE) && startReq;
    strobe.clrFrame = (state == ST_WAIT) && bitVal;
    strobe.takeHdr  = (state == ST_HEAD);
    strobe.takeData = (state == ST_DATA);
    strobe.takeCrc  = (state == ST_CRC);
  end

  assign lineOe  = (state == ST_ECHO) || (state == ST_FILL) || (state == ST_PRIME);
  assign busTick = lineOe || (state == ST_WAIT) || (state == ST_HEAD) ||
                   (state == ST_DATA) || (state == ST_CRC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      nBits    <= '0;
      busyCnt  <= '0;
      termMode <= 1'b0;
      pend     <= C_OK;
      txReq    <= 1'b0;
      txKind   <= TX_POLL;
      done     <= 1'b0;
      errCode  <= C_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (startReq) begin
          nBits    <= isRead ? CNT_W'({szEff, 3'b000}) : '0;
          busyCnt  <= '0;
          termMode <= 1'b0;
          cnt      <= '0;
          state    <= ST_ECHO;
        end
        ST_ECHO: if (cnt == ECHO_LAST) begin
          cnt   <= '0;
          state <= ST_WAIT;
        end else cnt <= cnt + 1'b1;
        ST_WAIT: if (bitVal) begin
          cnt   <= '0;
          state <= ST_HEAD;
        end else if (cnt == WAIT_LAST) begin
          cnt   <= '0;
          pend  <= termMode ? C_STUCK : C_TIMEOUT;
          state <= ST_PRIME;
        end else cnt <= cnt + 1'b1;
        ST_HEAD: if (cnt == NIB_LAST) begin
          cnt   <= '0;
          state <= (!termMode && nBits != '0 && tagLive == TAG_ACK) ? ST_DATA : ST_CRC;
        end else cnt <= cnt + 1'b1;
        ST_DATA: if (cnt == nBits - 1'b1) begin
          cnt   <= '0;
          state <= ST_CRC;
        end else cnt <= cnt + 1'b1;
        ST_CRC: if (cnt == NIB_LAST) begin
          cnt   <= '0;
          state <= ST_CHECK;
        end else cnt <= cnt + 1'b1;
        ST_CHECK: begin
          cnt   <= '0;
          state <= ST_PRIME;
          if (termMode)            pend <= C_STUCK;
          else if (!crcZero)       pend <= C_RESPCRC;
          else if (tagReg == TAG_ACK)  pend <= C_OK;
          else if (tagReg == TAG_BUSY) state <= ST_FILL;
          else if (tagReg == TAG_MISC) pend <= C_MISC;
          else                     pend <= C_SLVCRC;
        end
        ST_FILL: if (cnt == FILL_LAST) begin
          cnt   <= '0;
          txReq <= 1'b1;
          state <= ST_TXWAIT;
          if (busyCnt < BUSY_LIM) begin
            busyCnt <= busyCnt + 1'b1;
            txKind  <= TX_POLL;
          end else begin
            termMode <= 1'b1;
            txKind   <= TX_TERM;
          end
        end else cnt <= cnt + 1'b1;
        ST_TXWAIT: if (txDone) begin
          txReq <= 1'b0;
          cnt   <= '0;
          state <= ST_ECHO;
        end
        ST_PRIME: if (cnt == PRIME_LAST) begin
          cnt     <= '0;
          done    <= 1'b1;
          errCode <= pend;
          state   <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> txReq);
  p_data_on_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (tagReg == TAG_ACK && !termMode));
  p_busy_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txKind == TX_POLL) |-> (busyCnt <= BUSY_LIM));
  p_code_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode <= C_RESPCRC));

endmodule

// File: rtl/slave_resp_rx.sv
module slave_resp_rx
  import slave_resp_rx_pkg::*;
#(
  parameter int ECHO_CLKS  = 16,
  parameter int START_WAIT = 1000,
  parameter int FILL_CLKS  = 100,
  parameter int PRIME_CLKS = 100,
  parameter int MAX_BUSY   = 100,
  parameter int MAX_BYTES  = 4,
  parameter logic [3:0] CRC_POLY = 4'h7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startReq,
  input  logic                           isRead,
  input  logic [$clog2(MAX_BYTES+1)-1:0] sizeBytes,
  input  logic                           lineIn,
  output logic                           lineOe,
  output logic                           lineOut,
  output logic                           busTick,
  output logic                           txReq,
  output logic                           txKind,
  input  logic                           txDone,
  output logic                           done,
  output logic [2:0]                     errCode,
  output logic [MAX_BYTES*8-1:0]         rdData
);
  rxStrobe_t strobe;
  logic      bitVal;
  logic [1:0] tagLive, tagReg;
  logic      crcZero;
  txKind_e   kind;

  slave_resp_rx_ctrl #(
    .ECHO_CLKS(ECHO_CLKS), .START_WAIT(START_WAIT), .FILL_CLKS(FILL_CLKS),
    .PRIME_CLKS(PRIME_CLKS), .MAX_BUSY(MAX_BUSY), .MAX_BYTES(MAX_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead),
    .sizeBytes(sizeBytes), .bitVal(bitVal), .tagLive(tagLive), .tagReg(tagReg),
    .crcZero(crcZero), .txDone(txDone), .strobe(strobe), .busTick(busTick),
    .lineOe(lineOe), .txReq(txReq), .txKind(kind), .done(done), .errCode(errCode)
  );

  slave_resp_rx_dp #(.MAX_BYTES(MAX_BYTES), .CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIn(lineIn), .bitVal(bitVal),
    .tagLive(tagLive), .tagReg(tagReg), .crcZero(crcZero), .rdData(rdData)
  );

  assign lineOut = lineOe;   // idle level is high (logical zero)
  assign txKind  = kind;

endmodule

// File: tb/slave_resp_rx_tb.sv
module slave_resp_rx_tb;
  localparam int ECHO = 16, WAITN = 50, FILL = 100, PRIME = 100, MAXB = 3, NBYTES = 4;
  localparam int SZW = $clog2(NBYTES+1);

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic startReq = 1'b0, isRead = 1'b0, txDone = 1'b0, lineIn = 1'b1;
  logic [SZW-1:0] sizeBytes = '0;
  logic lineOe, lineOut, busTick, txReq, txKind, done;
  logic [2:0] errCode;
  logic [NBYTES*8-1:0] rdData;

  slave_resp_rx #(.ECHO_CLKS(ECHO), .START_WAIT(WAITN), .FILL_CLKS(FILL),
    .PRIME_CLKS(PRIME), .MAX_BUSY(MAXB), .MAX_BYTES(NBYTES)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead),
    .sizeBytes(sizeBytes), .lineIn(lineIn), .lineOe(lineOe), .lineOut(lineOut),
    .busTick(busTick), .txReq(txReq), .txKind(txKind), .txDone(txDone),
    .done(done), .errCode(errCode), .rdData(rdData));

  int errors = 0, checks = 0, cycles = 0;
  bit q[$];
  bit consumed = 0;
  int samples = 0, runLen = 0;
  int runs[$], expRuns[$], kinds[$], expKinds[$];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave line model, run recorder, per-clock comparison, watchdog
  always @(negedge clk) begin
    cycles++;
    if (consumed && q.size() > 0) void'(q.pop_front());
    lineIn   = (q.size() > 0) ? q[0] : 1'b1;
    consumed = busTick && !lineOe;
    if (consumed) samples++;
    if (lineOe) runLen++;
    else if (runLen > 0) begin runs.push_back(runLen); runLen = 0; end
    if (rstN && lineOe) chk("R2", "driven line is high and clocked",
                            {lineOut, busTick}, 2'b11);
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // transmitter model
  initial forever begin
    @(negedge clk);
    if (txReq && !txDone) begin
      kinds.push_back(int'(txKind));
      repeat (3) @(negedge clk);
      txDone = 1'b1;
      @(negedge clk);
      txDone = 1'b0;
    end
  end

  function automatic int crcOf(bit b[$]);
    int c = 0;
    foreach (b[i]) begin
      int fb = ((c >> 3) & 1) ^ int'(b[i]);
      c = (c << 1) & 15;
      if (fb != 0) c = c ^ 7;
    end
    return c;
  endfunction

  // queue one response: idle delay, then start, id, tag, data, check bits
  task automatic pushResp(int delay, bit [1:0] tag, int nb, logic [31:0] data, bit bad);
    bit lb[$];
    int c;
    lb.push_back(1'b1);
    lb.push_back(1'b1); lb.push_back(1'b0);
    lb.push_back(tag[1]); lb.push_back(tag[0]);
    for (int i = 0; i < nb; i++)
      for (int k = 7; k >= 0; k--) lb.push_back(data[i*8+k]);
    c = crcOf(lb);
    if (bad) c = c ^ 1;
    for (int k = 3; k >= 0; k--) lb.push_back(c[k]);
    for (int i = 0; i < delay; i++) q.push_back(1'b1);
    foreach (lb[i]) q.push_back(~lb[i]);
  endtask

  task automatic runOp(bit rd, int sz, int expCode, logic [31:0] expData,
                       int expSamples, int poke, string req);
    int n = 0;
    bit same;
    runs.delete(); kinds.delete(); samples = 0; runLen = 0;
    @(negedge clk);
    isRead = rd; sizeBytes = SZW'(sz); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke > 0) fork
      begin
        repeat (poke) @(negedge clk);
        startReq = 1'b1; isRead = 1'b0; sizeBytes = '0;
        @(negedge clk);
        startReq = 1'b0;
      end
    join_none
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(req, "done seen", done, 1);
    chk(req, "errCode", errCode, expCode);
    chk(req, "rdData", rdData, expData);
    @(negedge clk);
    chk("R9", "done lasts one cycle", done, 0);
    same = (runs.size() == expRuns.size());
    if (same) foreach (runs[i]) if (runs[i] != expRuns[i]) same = 0;
    chk("R2/R7/R9", {req, " driven run lengths match"}, same, 1);
    same = (kinds.size() == expKinds.size());
    if (same) foreach (kinds[i]) if (kinds[i] != expKinds[i]) same = 0;
    chk("R12", {req, " transmitter requests match"}, same, 1);
    if (expSamples >= 0) chk(req, "sampled bits", samples, expSamples);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "reset outputs", {lineOe, busTick, txReq, done, errCode}, 0);
    chk("R1", "reset data", rdData, 0);
    rstN = 1'b1;

    // write acknowledge
    q.delete(); pushResp(3, 2'd0, 0, 0, 0);
    expRuns = {ECHO, PRIME}; expKinds = {};
    runOp(0, 0, 0, 0, 12, 0, "R2 R4 write ack");

    // read 4 bytes, with a stray start request in the middle
    q.delete(); pushResp(2, 2'd0, 4, 32'h810F3CA5, 0);
    runOp(1, 4, 0, 32'h810F3CA5, 43, 30, "R5 R10 R11 read4");
    repeat (20) @(negedge clk);
    chk("R10", "rdData held after done", rdData, 32'h810F3CA5);

    q.delete(); pushResp(0, 2'd0, 2, 32'h0000BEEF, 0);
    runOp(1, 2, 0, 32'h0000BEEF, 25, 0, "R10 read2");

    // error tags: no data sampled even for a read
    q.delete(); pushResp(1, 2'd2, 0, 0, 0);
    runOp(1, 4, 2, 0, 10, 0, "R4 R5 misc error");
    q.delete(); pushResp(1, 2'd3, 0, 0, 0);
    runOp(1, 4, 3, 0, 10, 0, "R4 slave crc error");

    // bad check code, also on a busy tag (precedence)
    q.delete(); pushResp(4, 2'd0, 0, 0, 1);
    runOp(0, 0, 5, 0, 13, 0, "R6 bad crc");
    q.delete(); pushResp(0, 2'd1, 0, 0, 1);
    runOp(0, 0, 5, 0, 9, 0, "R6 bad crc on busy");

    // no response, and start on the last permitted sample
    q.delete();
    runOp(0, 0, 4, 0, WAITN, 0, "R3 timeout");
    q.delete(); pushResp(WAITN-1, 2'd0, 0, 0, 0);
    runOp(0, 0, 0, 0, WAITN+8, 0, "R3 last sample start");

    // two busy answers then a one-byte read acknowledge
    q.delete();
    pushResp(1, 2'd1, 0, 0, 0); pushResp(1, 2'd1, 0, 0, 0);
    pushResp(1, 2'd0, 1, 32'h5A, 0);
    expRuns = {ECHO, FILL, ECHO, FILL, ECHO, PRIME}; expKinds = {0, 0};
    runOp(1, 1, 0, 32'h5A, 38, 0, "R7 busy retry");

    // stuck busy: MAXB polls then terminate
    q.delete();
    for (int i = 0; i <= MAXB; i++) pushResp(0, 2'd1, 0, 0, 0);
    pushResp(0, 2'd0, 0, 0, 0);
    expRuns = {ECHO};
    for (int i = 0; i <= MAXB; i++) begin expRuns.push_back(FILL); expRuns.push_back(ECHO); end
    expRuns.push_back(PRIME);
    expKinds = {};
    for (int i = 0; i < MAXB; i++) expKinds.push_back(0);
    expKinds.push_back(1);
    runOp(1, 2, 1, 0, 9*(MAXB+2), 0, "R8 stuck busy");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule